// File: doc/BRIEF.md
# Misaligned Access Splitter for a 16-bit Bus

This block sits between a processor's data-access port and a 16-bit external data bus. It takes one access request at a time. A request is a byte, halfword or word read or write, at any byte address. It turns the request into an ordered series of bus cycles. Each cycle is either byte-wide or halfword-wide and drives its own address, width flag, byte-lane enables and write data. An access at a misaligned address is never rejected. It is broken into smaller cycles at ascending addresses, least significant byte first.

On a read, the pieces returned by the bus are merged into one right-justified, zero-extended result. The result is presented with a single-cycle completion pulse. On a write, the datum is sliced into the bytes each cycle needs. Every bus cycle is held until the bus acknowledges it. A lock output covers the whole series, so that no other master can slip in between the pieces.

Top module: `mas_splitter`

## Requirements
- R1: Size encoding is 00 = byte, 01 = halfword, 1x = word. A byte access produces exactly one byte cycle at the request address.
- R2: A halfword access at an even address produces one halfword cycle at that address. At an odd address it produces two byte cycles, at addr and then addr+1.
- R3: A word access whose two low address bits are 00 or 10 produces two halfword cycles, at addr and then addr+2.
- R4: A word access at an odd address produces, in order, a byte cycle at addr, a halfword cycle at addr+1 and a byte cycle at addr+3.
- R5: The lane enables are as follows. bus_lane bit 0 is the low lane (data bits 7:0) and bit 1 is the high lane (bits 15:8). A halfword cycle enables both lanes and always has an even address. A byte cycle enables only the low lane at an even address and only the high lane at an odd address.
- R6: Write data is little-endian. The cycle at byte offset k from the request address carries datum byte k. A halfword cycle puts byte k on the low lane and byte k+1 on the high lane. A byte cycle repeats its byte on both lanes.
- R7: A read result is built from the returned pieces in little-endian order. A byte cycle takes the byte from its enabled lane only. The result is zero-extended for byte and halfword sizes.
- R8: done is high for exactly one cycle, in the cycle after the acknowledge of the last piece. At that point rdata holds the read result.
- R9: req_ready is low from the cycle after a request is accepted until done. A req_valid seen while not ready is ignored and produces no extra bus cycles.
- R10: bus_lock is high for every cycle in which bus_req is high. While a cycle waits for bus_ack, its address, width, lanes and data stay unchanged.
- R11: After reset, req_ready is 1 and bus_req, bus_lock and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 32 | Write datum, right-justified |
| req_ready | output | 1 | Block idle, a request is taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read result |
| bus_req | output | 1 | Bus cycle in progress |
| bus_wr | output | 1 | Bus cycle direction |
| bus_addr | output | AW | Bus cycle address |
| bus_half | output | 1 | 1 = halfword cycle, 0 = byte cycle |
| bus_lane | output | 2 | Byte-lane enables (bit 0 low lane) |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_lock | output | 1 | Hold off other masters |

## Verification
The assertions assume three things about the inputs. bus_ack is asserted only while bus_req is high. bus_ack is low during reset. req_valid may arrive at any time, because it is ignored while busy. The bench's bus responder raises an acknowledge only after it sees bus_req, after a random wait of zero to two cycles. It always drops the acknowledge for at least one cycle between pieces. Requests use random sizes, random data and random addresses spread across all four low-bit alignments. Directed cases cover each alignment and a request strobe issued in the middle of an access.

// File: rtl/mas_pkg.sv
// Shared definitions for the misaligned access splitter.
// Holds the decomposition rule: for a given size, low address bits and piece
// index, it gives the piece width and its byte offset from the request address.
package mas_pkg;

    localparam int DATA_W   = 32;
    localparam int BUS_W    = 16;
    localparam int NBYTES   = DATA_W / 8;
    localparam int OFF_W    = $clog2(NBYTES);
    localparam int MAX_PCS  = 3;
    localparam int PIDX_W   = $clog2(MAX_PCS);

    typedef struct packed {
        logic              half;   // 1 = halfword cycle
        logic [OFF_W-1:0]  off;    // byte offset from request address
    } piece_t;

    // Width and offset of piece idx
    function automatic piece_t piece_of(input logic [1:0] sz,
                                        input logic [1:0] alo,
                                        input logic [PIDX_W-1:0] idx);
        piece_t p;
        p = '{half: 1'b0, off: '0};
        if (sz[1]) begin
            if (alo[0]) begin
                case (idx)
                    2'd0:    p = '{half: 1'b0, off: 2'd0};
                    2'd1:    p = '{half: 1'b1, off: 2'd1};
                    default: p = '{half: 1'b0, off: 2'd3};
                endcase
            end else begin
                p = (idx == 2'd0) ? '{half: 1'b1, off: 2'd0}
                                  : '{half: 1'b1, off: 2'd2};
            end
        end else if (sz[0]) begin
            if (alo[0]) p = (idx == 2'd0) ? '{half: 1'b0, off: 2'd0}
                                          : '{half: 1'b0, off: 2'd1};
            else        p = '{half: 1'b1, off: 2'd0};
        end
        return p;
    endfunction

    // Index of the final piece
    function automatic logic [PIDX_W-1:0] last_idx(input logic [1:0] sz,
                                                   input logic [1:0] alo);
        if (sz[1])      return alo[0] ? 2'd2 : 2'd1;
        else if (sz[0]) return alo[0] ? 2'd1 : 2'd0;
        else            return 2'd0;
    endfunction

endpackage

// File: rtl/mas_planner.sv
// Piece planner: for the access in flight, gives the current piece's width
// and offset, and says whether it is the final piece.
// Assumes: sz/alo are held stable for the whole access.
module mas_planner
    import mas_pkg::*;
(
    input  logic [1:0]        sz,
    input  logic [1:0]        alo,
    input  logic [PIDX_W-1:0] idx,
    output piece_t            pc,
    output logic              last
);

    // Look up the current piece and the end-of-series flag
    always_comb begin
        pc   = piece_of(sz, alo, idx);
        last = (idx == last_idx(sz, alo));
    end

endmodule

// File: rtl/mas_lane_steer.sv
// Lane steering: maps a piece onto the 16-bit bus lanes.
// Write: a byte piece is repeated on both lanes. Read: a byte piece is taken
// from the lane its address selects and normalised into bits 7:0.
// Assumes: halfword pieces are always at even addresses.
module mas_lane_steer #(
    parameter int BW = 16
) (
    input  logic          half,
    input  logic          addr0,
    input  logic [BW-1:0] wbytes,
    input  logic [BW-1:0] bus_rd,
    output logic [1:0]    lane,
    output logic [BW-1:0] bus_wd,
    output logic [BW-1:0] piece_rd
);

    localparam int HB = BW / 2;

    // Choose lanes and place write/read bytes
    always_comb begin
        if (half) begin
            lane     = 2'b11;
            bus_wd   = wbytes;
            piece_rd = bus_rd;
        end else begin
            lane     = addr0 ? 2'b10 : 2'b01;
            bus_wd   = {wbytes[HB-1:0], wbytes[HB-1:0]};
            piece_rd = {{HB{1'b0}}, (addr0 ? bus_rd[BW-1:HB] : bus_rd[HB-1:0])};
        end
    end

endmodule

// File: rtl/mas_assembler.sv
// Read assembler: stores each returned piece into its byte slots of the
// result register; clears at the start of every access (zero extension).
// Assumes: capture only happens on read pieces with off+width within the word.
module mas_assembler
    import mas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [OFF_W-1:0]  off,
    input  logic              half,
    input  logic [BUS_W-1:0]  piece,
    output logic [DATA_W-1:0] word
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        logic sel_lo, sel_hi;

        // Decide whether this byte slot takes the low or high piece byte
        always_comb begin
            sel_lo = (k == int'(off));
            sel_hi = half && (k == int'(off) + 1);
        end

        // Byte slot register
        always_ff @(posedge clk) begin
            if (!rst_n || clear)           word[8*k +: 8] <= '0;
            else if (capture && sel_lo)    word[8*k +: 8] <= piece[7:0];
            else if (capture && sel_hi)    word[8*k +: 8] <= piece[15:8];
        end
    end

endmodule

// File: rtl/mas_splitter.sv
// Misaligned access splitter, top level.
// Takes one access when idle and runs its pieces on the 16-bit bus one after
// another. Each piece is held until bus_ack. A done pulse follows the last ack.
// Assumes: bus_ack only while bus_req; req_valid while busy is ignored.
module mas_splitter
    import mas_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_half,
    output logic [1:0]        bus_lane,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ack,
    output logic              bus_lock
);

    logic              busy_q;
    logic              wr_q;
    logic [1:0]        sz_q;
    logic [AW-1:0]     base_q;
    logic [DATA_W-1:0] wdat_q;
    logic [PIDX_W-1:0] idx_q;
    logic              done_q;

    piece_t            pc;
    logic              last;
    logic              accept;
    logic              step;
    logic [DATA_W-1:0] wshift;
    logic [BUS_W-1:0]  piece_rd;

    mas_planner u_plan (
        .sz   (sz_q),
        .alo  (base_q[1:0]),
        .idx  (idx_q),
        .pc   (pc),
        .last (last)
    );

    // Handshake qualifiers and write slice for the current piece
    always_comb begin
        accept   = req_valid && !busy_q;
        step     = busy_q && bus_ack;
        wshift   = wdat_q >> {pc.off, 3'b000};
        bus_addr = base_q + {{(AW-OFF_W){1'b0}}, pc.off};
    end

    mas_lane_steer #(.BW(BUS_W)) u_steer (
        .half     (pc.half),
        .addr0    (bus_addr[0]),
        .wbytes   (wshift[BUS_W-1:0]),
        .bus_rd   (bus_rdata),
        .lane     (bus_lane),
        .bus_wd   (bus_wdata),
        .piece_rd (piece_rd)
    );

    mas_assembler u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (step && !wr_q),
        .off     (pc.off),
        .half    (pc.half),
        .piece   (piece_rd),
        .word    (rdata)
    );

    // Access sequencer: latch request, advance pieces, finish with done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            sz_q   <= '0;
            base_q <= '0;
            wdat_q <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                wr_q   <= req_write;
                sz_q   <= req_size;
                base_q <= req_addr;
                wdat_q <= req_wdata;
                idx_q  <= '0;
            end else if (step) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Drive handshake and bus control outputs from sequencer state
    always_comb begin
        req_ready = !busy_q;
        done      = done_q;
        bus_req   = busy_q;
        bus_lock  = busy_q;
        bus_wr    = wr_q;
        bus_half  = pc.half;
    end

endmodule

// File: rtl/mas_splitter_chk.sv
// Property checker for mas_splitter, bound to every instance.
// Assumes: bus_ack low during reset and only while bus_req.
module mas_splitter_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic          bus_half,
    input logic [1:0]    bus_lane,
    input logic [15:0]   bus_wdata,
    input logic          bus_ack,
    input logic          bus_lock
);

    a_r10_lock_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_lock);

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_half)
                                   && $stable(bus_lane) && $stable(bus_wdata)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_ack) && !bus_req));

    a_r9_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);

    a_r5_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_half) |-> (bus_lane == (bus_addr[0] ? 2'b10 : 2'b01)));

    a_r5_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_half) |-> (!bus_addr[0] && bus_lane == 2'b11));

endmodule

bind mas_splitter mas_splitter_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_half  (bus_half),
    .bus_lane  (bus_lane),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_lock  (bus_lock)
);

// File: tb/mas_splitter_tb_top.sv
// Bench for mas_splitter: random and directed accesses against a byte-array
// bus model. The expected cycle series and results come from bench functions.
module mas_splitter_tb_top;

    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done, bus_req, bus_wr, bus_half, bus_lock;
    logic [31:0] rdata;
    logic [AW-1:0] bus_addr;
    logic [1:0]  bus_lane;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [7:0]  bus_mem [0:255];
    logic [7:0]  ref_mem [0:255];
    logic [AW-1:0] log_addr [0:3];
    logic        log_half [0:3];
    logic [1:0]  log_lane [0:3];
    logic [15:0] log_wd   [0:3];
    int          n_log = 0;
    int          lock_bad = 0;

    always #2.5 clk = ~clk;

    mas_splitter #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .bus_req(bus_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_half(bus_half),
        .bus_lane(bus_lane), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_lock(bus_lock)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected series from R1..R4
    function automatic int exp_n(input logic [1:0] sz, input logic [1:0] alo);
        if (sz[1]) return alo[0] ? 3 : 2;
        if (sz[0]) return alo[0] ? 2 : 1;
        return 1;
    endfunction

    function automatic int exp_off(input logic [1:0] sz, input logic [1:0] alo, input int k);
        if (sz[1] && alo[0]) return (k == 0) ? 0 : (k == 1) ? 1 : 3;
        if (sz[1])           return 2 * k;
        return k;
    endfunction

    function automatic bit exp_half(input logic [1:0] sz, input logic [1:0] alo, input int k);
        if (sz[1] && alo[0]) return (k == 1);
        if (sz[1])           return 1'b1;
        if (sz[0])           return !alo[0];
        return 1'b0;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return sz[1] ? 4 : (sz[0] ? 2 : 1);
    endfunction

    // Bus responder: random wait, ack one cycle, log and apply the cycle
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                wait_n  = $urandom_range(0, 2);
            end else if (bus_req && rst_n) begin
                if (wait_n > 0) wait_n--;
                else begin
                    if (n_log < 4) begin
                        log_addr[n_log] = bus_addr;
                        log_half[n_log] = bus_half;
                        log_lane[n_log] = bus_lane;
                        log_wd[n_log]   = bus_wdata;
                    end
                    n_log++;
                    if (!bus_lock) lock_bad++;
                    if (bus_wr) begin
                        if (bus_lane[0]) bus_mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
                        if (bus_lane[1]) bus_mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
                    end
                    bus_rdata[7:0]  = bus_lane[0] ? bus_mem[{bus_addr[7:1], 1'b0}] : 8'($urandom);
                    bus_rdata[15:8] = bus_lane[1] ? bus_mem[{bus_addr[7:1], 1'b1}] : 8'($urandom);
                    bus_ack = 1'b1;
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_op(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] d, input bit poke);
        logic [31:0] exp_rd;
        int n, t, busy_bad;
        bit got;
        n = exp_n(sz, a[1:0]);
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready before request", {31'b0, req_ready}, 32'd1);
        n_log = 0; lock_bad = 0; busy_bad = 0;
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = {{(AW-8){1'b0}}, a}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_write = ~wr; req_size = 2'b10;
            req_addr = {{(AW-8){1'b0}}, a ^ 8'h40}; req_wdata = ~d;
        end
        got = 1'b0;
        for (t = 0; t < 60; t++) begin
            if (done) begin got = 1'b1; break; end
            if (req_ready) busy_bad++;
            if (bus_req && !bus_lock) busy_bad++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        check(got, "R8", "done seen", {31'b0, got}, 32'd1);
        check(busy_bad == 0, "R9", "ready low and lock high while busy", busy_bad, 0);
        check(lock_bad == 0, "R10", "lock during acked cycles", lock_bad, 0);
        check(n_log == n, "R9", "bus cycle count", n_log, n);
        for (int k = 0; k < n && k < n_log && k < 4; k++) begin
            logic [7:0] ea;
            logic [1:0] el;
            logic [15:0] ew;
            ea = a + 8'(exp_off(sz, a[1:0], k));
            check(log_addr[k] == {{(AW-8){1'b0}}, ea}, sz[1] ? (a[0] ? "R4" : "R3") : (sz[0] ? "R2" : "R1"),
                  "cycle address", log_addr[k], {24'b0, ea});
            check(log_half[k] == exp_half(sz, a[1:0], k), "R2", "cycle width",
                  {31'b0, log_half[k]}, {31'b0, exp_half(sz, a[1:0], k)});
            el = exp_half(sz, a[1:0], k) ? 2'b11 : (ea[0] ? 2'b10 : 2'b01);
            check(log_lane[k] == el, "R5", "lane enables", {30'b0, log_lane[k]}, {30'b0, el});
            if (wr) begin
                int o;
                o = exp_off(sz, a[1:0], k);
                ew = exp_half(sz, a[1:0], k) ? 16'(d >> (8 * o)) : {2{d[8*o +: 8]}};
                check(log_wd[k] == ew, "R6", "write slice", {16'b0, log_wd[k]}, {16'b0, ew});
            end
        end
        exp_rd = '0;
        for (int b = 0; b < nbytes(sz); b++) begin
            if (wr) ref_mem[a + 8'(b)] = d[8*b +: 8];
            else    exp_rd[8*b +: 8] = ref_mem[a + 8'(b)];
        end
        if (wr) begin
            for (int b = 0; b < 4; b++)
                check(bus_mem[a + 8'(b)] == ref_mem[a + 8'(b)], "R6", "memory after write",
                      {24'b0, bus_mem[a + 8'(b)]}, {24'b0, ref_mem[a + 8'(b)]});
        end else begin
            check(rdata == exp_rd, "R7", "read result", rdata, exp_rd);
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", {31'b0, done}, 32'd0);
        if (!wr) check(rdata == exp_rd, "R8", "rdata held", rdata, exp_rd);
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 256; i++) begin
            bus_mem[i] = 8'($urandom);
            ref_mem[i] = bus_mem[i];
        end
        repeat (4) @(negedge clk);
        check(req_ready == 1'b1, "R11", "reset ready", {31'b0, req_ready}, 32'd1);
        check(bus_req == 1'b0, "R11", "reset bus_req", {31'b0, bus_req}, 32'd0);
        check(bus_lock == 1'b0, "R11", "reset lock", {31'b0, bus_lock}, 32'd0);
        check(done == 1'b0, "R11", "reset done", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        // Directed: each alignment, each size, write then read back
        for (int al = 0; al < 4; al++) begin
            for (int s = 0; s < 3; s++) begin
                logic [7:0] a;
                a = 8'(16 + 8 * (3 * al + s) + al);
                do_op(1'b1, 2'(s), a, 32'hA1B2C3D4 ^ 32'(al * 7 + s), 1'b0);
                do_op(1'b0, 2'(s), a, 32'h0, 1'b0);
            end
        end
        // Directed: request strobe while busy is ignored (R9)
        do_op(1'b0, 2'b10, 8'd9, 32'h0, 1'b1);
        do_op(1'b1, 2'b11, 8'd33, 32'h11223344, 1'b1);
        do_op(1'b0, 2'b01, 8'd33, 32'h0, 1'b0);
        // Random mix
        for (int i = 0; i < 160; i++) begin
            do_op(1'($urandom), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 250)),
                  $urandom, ($urandom_range(0, 7) == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule